// File: doc/BRIEF.md
# Gated serial clock divider

This block derives the serial flash clock from a reference clock. Host register fields drive the controls:
- two enables: a run enable and a second, boot-path enable;
- a log-coded divide select;
- a phase select.

The divided clock runs whenever either enable is set. When both enables are cleared, the block does not cut the clock at once. It waits until the current serial clock period has finished and any bus-side access has drained. Only then does it halt the output low and raise a clock-halted status. A separate idle status follows the serial engine's busy indication.

The divide and phase settings are copied into internal holding registers only while the clock is halted. Values the host writes while the clock runs have no effect until the clock is stopped and started again. The host therefore follows a fixed sequence:
1. Clear both enables.
2. Wait for the halted and idle statuses.
3. Write the new settings.
4. Set an enable.
5. Watch the halted status drop.

Top module: `sclk_gate_ctrl`

## Requirements
- R1: During and right after reset, `clk_halted` is 1, `sclk_out` is 0 and `eng_idle` is 1.
- R2: Divide code 0, 1, 2 and 3 gives a serial clock period of 1, 2, 4 and 8 reference cycles.
- R3: For codes 2 and 3, phase 0 puts the first rising edge ratio/2 reference cycles after restart, and phase 1 puts it ratio/4 cycles after restart. For codes 0 and 1 the phase bit is ignored and the first rising edge comes 1 cycle after restart.
- R4: The clock runs while either `run_en` or `boot_en` is 1. Setting only `boot_en` is enough to run it, and it halts only when both are 0.
- R5: When the clock halts, its last high pulse has full width: ratio/2 reference cycles, or half a cycle for code 0. The output then stays low with no further edges.
- R6: For codes 1 to 3, `clk_halted` rises on the same reference edge that drives the final falling edge of `sclk_out`. For code 0, that falling edge follows half a cycle later.
- R7: While `bus_busy` is 1 the clock keeps running and `clk_halted` stays 0, even with both enables cleared.
- R8: Divide and phase inputs are captured only while halted. A change made while the clock runs keeps the old period until the next stop and restart, and the new value applies after that.
- R9: `clk_halted` falls on the first reference rising edge at which an enable is seen set.
- R10: `eng_idle` equals the inverse of `eng_busy` as sampled on the previous reference rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Internal clock enable |
| boot_en | input | 1 | Second (boot-path) clock enable |
| div_sel | input | DIV_W (2) | Log-coded divide: ratio = 2^code |
| phase_sel | input | 1 | 0: 180-degree start, 1: 90-degree start |
| eng_busy | input | 1 | Serial engine has a transfer in progress |
| bus_busy | input | 1 | Bus-side read or write still active |
| sclk_out | output | 1 | Divided (or gated) serial clock |
| clk_halted | output | 1 | Serial clock has stopped |
| eng_idle | output | 1 | Serial engine idle |

## Verification
Status outputs are registered. `clk_halted` changes on the first reference edge after the enable change, and `eng_idle` changes one edge after `eng_busy`; the bench drives inputs on falling edges and samples on the next falling edge. Clock-shape results (first rise, period, last pulse width, halt alignment) are timestamped at the actual edges of `sclk_out` and `clk_halted`. They are compared against multiples of the reference period worked out from the code, so they do not depend on when a sample is taken. Absence of edges after a halt is checked by counting rising edges over a ten-cycle window.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
   typedef enum logic {
      ST_HALT = 1'b0,
      ST_RUN  = 1'b1
   } sclk_state_e;
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
   parameter int DIV_W = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] div_in,
   input  logic             ph_in,
   output logic [DIV_W-1:0] div_q,
   output logic             ph_q
);
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         ph_q  <= 1'b0;
      end else if (load) begin
         div_q <= div_in;
         ph_q  <= ph_in;
      end
   end
endmodule

// File: rtl/sclk_stop_ctrl.sv
module sclk_stop_ctrl
   import sclk_pkg::*;
(
   input  logic clk_ref,
   input  logic rst_n,
   input  logic run_en,
   input  logic boot_en,
   input  logic bus_busy,
   input  logic eng_busy,
   input  logic period_end,
   output logic run,
   output logic start,
   output logic halted,
   output logic idle
);
   sclk_state_e state_q;
   logic        en_any;
   logic        stop;

   assign en_any = run_en | boot_en;
   assign start  = (state_q == ST_HALT) & en_any;
   assign stop   = (state_q == ST_RUN) & ~en_any & ~bus_busy & period_end;
   assign run    = (state_q == ST_RUN);
   assign halted = (state_q == ST_HALT);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HALT;
         idle    <= 1'b1;
      end else begin
         idle <= ~eng_busy;
         if (start)
            state_q <= ST_RUN;
         else if (stop)
            state_q <= ST_HALT;
      end
   end

   AST_HALT_NEEDS_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(halted) |-> $past(!run_en && !boot_en && !bus_busy)) else $error("halt too early"); // R7
   AST_RUN_WHILE_EN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (run && (run_en || boot_en)) |=> run) else $error("stopped while enabled"); // R4
   AST_IDLE_FOLLOWS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      eng_busy |=> !idle) else $error("idle while busy"); // R10
endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core #(
   parameter int DIV_W = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             run,
   input  logic             start,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_ph,
   output logic             sclk_out,
   output logic             period_end
);
   localparam int MAX_CODE = (1 << DIV_W) - 1;
   localparam int MAX_HALF = 1 << (MAX_CODE - 1);
   localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

   generate
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_width
         $error("sclk_div_core: DIV_W must be 1..4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   logic [CNT_W-1:0] start_val;
   logic             div_q;
   logic             gate_q;
   logic             bypass;

   assign bypass = (cfg_div == '0);

   always_comb begin
      half_m1   = '0;
      start_val = '0;
      for (int i = 1; i <= MAX_CODE; i++) begin
         if (cfg_div == DIV_W'(i)) begin
            half_m1 = CNT_W'((1 << (i - 1)) - 1);
            if (cfg_ph && i >= 2)
               start_val = CNT_W'(1 << (i - 2));
         end
      end
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if (start) begin
         cnt_q <= start_val;
         div_q <= 1'b0;
      end else if (run && !bypass) begin
         if (cnt_q == half_m1) begin
            cnt_q <= '0;
            div_q <= ~div_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (!run) begin
         cnt_q <= '0;
         div_q <= 1'b0;
      end
   end

   always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n)
         gate_q <= 1'b0;
      else
         gate_q <= run & bypass;
   end

   assign period_end = bypass | (div_q & (cnt_q == half_m1));
   assign sclk_out   = bypass ? (clk_ref & gate_q) : div_q;

   AST_HALT_OUT_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !run |-> !div_q) else $error("divided clock high while halted"); // R5
   AST_CNT_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (run && !bypass) |-> (cnt_q <= half_m1)) else $error("counter beyond half period"); // R2
endmodule

// File: rtl/sclk_gate_ctrl.sv
module sclk_gate_ctrl #(
   parameter int DIV_W = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             boot_en,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             phase_sel,
   input  logic             eng_busy,
   input  logic             bus_busy,
   output logic             sclk_out,
   output logic             clk_halted,
   output logic             eng_idle
);
   logic             run;
   logic             start;
   logic             period_end;
   logic [DIV_W-1:0] cfg_div;
   logic             cfg_ph;

   sclk_stop_ctrl u_ctrl (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .boot_en    (boot_en),
      .bus_busy   (bus_busy),
      .eng_busy   (eng_busy),
      .period_end (period_end),
      .run        (run),
      .start      (start),
      .halted     (clk_halted),
      .idle       (eng_idle)
   );

   sclk_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .load    (clk_halted & ~start),
      .div_in  (div_sel),
      .ph_in   (phase_sel),
      .div_q   (cfg_div),
      .ph_q    (cfg_ph)
   );

   sclk_div_core #(.DIV_W(DIV_W)) u_div (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .run        (run),
      .start      (start),
      .cfg_div    (cfg_div),
      .cfg_ph     (cfg_ph),
      .sclk_out   (sclk_out),
      .period_end (period_end)
   );

   AST_CFG_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (run && $past(run)) |-> ($stable(cfg_div) && $stable(cfg_ph))) else $error("config moved while running"); // R8
endmodule

// File: tb/sim_sclk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_sclk_gate_ctrl;
   logic       clk_ref = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0, boot_en = 1'b0;
   logic [1:0] div_sel = 2'd0;
   logic       phase_sel = 1'b0;
   logic       eng_busy = 1'b0, bus_busy = 1'b0;
   logic       sclk_out, clk_halted, eng_idle;

   int total = 0, bad = 0;
   int rise_n = 0;
   int rt [0:255];
   int last_rise = 0, last_fall = 0, t_run = 0, t_halt = 0;

   // {div[1:0], phase, first-rise cycles[4:0], period cycles[7:0]}
   localparam logic [15:0] VEC [8] = '{
      {2'd0, 1'b0, 5'd1, 8'd1}, {2'd0, 1'b1, 5'd1, 8'd1},
      {2'd1, 1'b0, 5'd1, 8'd2}, {2'd1, 1'b1, 5'd1, 8'd2},
      {2'd2, 1'b0, 5'd2, 8'd4}, {2'd2, 1'b1, 5'd1, 8'd4},
      {2'd3, 1'b0, 5'd4, 8'd8}, {2'd3, 1'b1, 5'd2, 8'd8}
   };

   always #2.5 clk_ref = ~clk_ref;

   sclk_gate_ctrl u0 (
      .clk_ref(clk_ref), .rst_n(rst_n), .run_en(run_en), .boot_en(boot_en),
      .div_sel(div_sel), .phase_sel(phase_sel), .eng_busy(eng_busy),
      .bus_busy(bus_busy), .sclk_out(sclk_out), .clk_halted(clk_halted),
      .eng_idle(eng_idle)
   );

   function automatic int now_ps();
      return $rtoi($realtime * 1000.0);
   endfunction

   always @(posedge sclk_out) begin
      rt[rise_n % 256] = now_ps();
      last_rise = now_ps();
      rise_n++;
   end
   always @(negedge sclk_out) last_fall = now_ps();
   always @(negedge clk_halted) t_run = now_ps();
   always @(posedge clk_halted) t_halt = now_ps();

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_rises(int base, int n, int limit);
      for (int i = 0; i < limit; i++) begin
         if (rise_n >= base + n) break;
         @(negedge clk_ref);
      end
   endtask

   task automatic wait_halt(int limit);
      for (int i = 0; i < limit; i++) begin
         if (clk_halted) break;
         @(negedge clk_ref);
      end
   endtask

   task automatic period_now(string req, int exp_cycles);
      int base;
      base = rise_n;
      wait_rises(base, 3, 100);
      chk(req, rt[(base + 2) % 256] - rt[(base + 1) % 256], exp_cycles * 5000);
   endtask

   initial begin
      repeat (150000) @(posedge clk_ref);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk_ref);
      chk("R1 halted in reset", clk_halted, 1);
      chk("R1 sclk in reset", sclk_out, 0);
      chk("R1 idle in reset", eng_idle, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk_ref);
      chk("R1 halted after reset", clk_halted, 1);
      chk("R1 sclk after reset", sclk_out, 0);

      // table walk: R2 R3 R5 R6 R9
      for (int v = 0; v < 8; v++) begin
         int base, te, per, fst, dv, cnt0;
         dv  = int'(VEC[v][15:14]);
         fst = int'(VEC[v][12:8]);
         per = int'(VEC[v][7:0]);
         div_sel = VEC[v][15:14];
         phase_sel = VEC[v][13];
         repeat (2) @(negedge clk_ref);
         base = rise_n;
         run_en = 1'b1;
         te = now_ps();
         wait_rises(base, 3, 100);
         chk("R9 restart latency", t_run - te, 2500);
         chk("R3 first rise", rt[base % 256] - t_run, fst * 5000);
         chk("R2 period", rt[(base + 2) % 256] - rt[(base + 1) % 256], per * 5000);
         run_en = 1'b0;
         wait_halt(40);
         repeat (2) @(negedge clk_ref);
         chk("R6 halt alignment", last_fall - t_halt, (dv == 0) ? 2500 : 0);
         chk("R5 last pulse width", last_fall - last_rise, per * 2500);
         cnt0 = rise_n;
         repeat (10) @(negedge clk_ref);
         chk("R5 no edges while halted", rise_n - cnt0, 0);
         chk("R5 low while halted", sclk_out, 0);
      end

      // R10: idle status follows busy one edge later
      eng_busy = 1'b1;
      @(negedge clk_ref);
      chk("R10 idle drops", eng_idle, 0);
      eng_busy = 1'b0;
      @(negedge clk_ref);
      chk("R10 idle returns", eng_idle, 1);

      // R4: boot enable alone runs the clock
      div_sel = 2'd1; phase_sel = 1'b0;
      repeat (2) @(negedge clk_ref);
      boot_en = 1'b1;
      period_now("R4 boot enable runs", 2);
      chk("R4 not halted under boot enable", clk_halted, 0);
      run_en = 1'b1; boot_en = 1'b0;
      repeat (20) @(negedge clk_ref);
      chk("R4 still running on run enable", clk_halted, 0);
      run_en = 1'b0;
      wait_halt(20);
      chk("R4 halts with both clear", clk_halted, 1);

      // R7: bus activity holds off the halt
      div_sel = 2'd3;
      repeat (2) @(negedge clk_ref);
      run_en = 1'b1;
      wait_rises(rise_n, 2, 50);
      bus_busy = 1'b1;
      run_en = 1'b0;
      begin
         int c0;
         c0 = rise_n;
         repeat (60) @(negedge clk_ref);
         chk("R7 not halted while bus busy", clk_halted, 0);
         chk("R7 clock keeps toggling", (rise_n - c0) >= 6, 1);
      end
      bus_busy = 1'b0;
      wait_halt(20);
      chk("R7 halts after bus drains", clk_halted, 1);

      // R8: settings written while running are held
      div_sel = 2'd3;
      repeat (2) @(negedge clk_ref);
      run_en = 1'b1;
      wait_rises(rise_n, 1, 50);
      div_sel = 2'd1;
      period_now("R8 old period kept while running", 8);
      run_en = 1'b0;
      wait_halt(40);
      repeat (2) @(negedge clk_ref);
      run_en = 1'b1;
      period_now("R8 new period after restart", 2);
      run_en = 1'b0;
      wait_halt(20);
      chk("R8 halted at end", clk_halted, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule